// File: doc/BRIEF.md
# Interrupt Cause Register Unit

This block is one group of interrupt cause bits behind a small register-bus slave. Hardware raises single-cycle event pulses on a vector input and each pulse latches into its cause bit, where it stays until software clears it. Software can also raise any cause bit itself, mask or unmask bits through two separate strobe registers, and decide, bit by bit, whether a cause bit is cleared by reading the cause register or by writing a one to it.

The block drives one interrupt line: the OR of every cause bit whose mask bit is clear. A parent instantiates one copy per source group (transmit, receive, miscellaneous) and ORs the three lines into its summary register. Read data is registered and appears on the cycle after the read strobe.

Register selectors on `bus_addr`: 0 cause, 1 cause-set (write only), 2 mask-set (write only), 3 mask-clear (write only), 4 clear-mode, 5 mask value (read only), 6 pending (read only). Selector 7 is unused.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, every clear-mode bit is 0, and `irq_out` is low.
- R2: A 1 on bit i of `hw_evt` during a clock edge sets cause bit i, and the bit stays set until software clears it.
- R3: A write to selector 1 sets every cause bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to selector 0 clears cause bit i only when write-data bit i is 1 and clear-mode bit i is 0; cause bits in clear-on-read mode are unaffected by writes.
- R5: A read of selector 0 returns the cause bits as they were before the read edge and clears exactly those bits whose clear-mode bit is 1; bits in mode 0 keep their value.
- R6: A write to selector 2 sets the mask bits where write-data is 1; zero bits leave the mask unchanged.
- R7: A write to selector 3 clears the mask bits where write-data is 1; zero bits leave the mask unchanged.
- R8: Selector 4 holds the clear-mode word, written and read back as a whole (1 = clear-on-read, 0 = write-one-to-clear); with the value 0xF7FFFFFF, bit 27 alone stays write-one-to-clear.
- R9: Selector 5 reads the mask word; selector 6 reads cause AND NOT mask and leaves the cause bits unchanged.
- R10: `irq_out` is high exactly when some cause bit is set with its mask bit clear, valid in the cycle after the register change.
- R11: When a hardware event and a clearing read or write hit the same bit in the same cycle, the bit ends up set.
- R12: `bus_rdata` carries the selected register in the cycle after `bus_rd` and is zero otherwise; write-only and unused selectors read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register selector |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| hw_evt | input | W | Hardware event pulses, one per cause bit |
| irq_out | output | 1 | Masked interrupt request |

## Verification
The clear logic is driven with all bits in write-one-to-clear mode, then with the mixed 0xF7FFFFFF mode word, so a bench that confuses the two modes sees a clear-on-read bit survive a read or a write-one-to-clear bit vanish on a read. Mask words are written with zero-only and single-bit patterns to separate set and clear strobes from a plain load. Collisions between an event and a clearing read, and between an event and a clearing write, show whether the event takes priority, and the pending read with an unchanged cause afterwards shows it has no side effect.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CAUSE = 3'd0,
        SEL_SET   = 3'd1,
        SEL_MSET  = 3'd2,
        SEL_MCLR  = 3'd3,
        SEL_MODE  = 3'd4,
        SEL_MVAL  = 3'd5,
        SEL_PEND  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cause_rd;
        logic cause_wr;
        logic set_wr;
        logic mset_wr;
        logic mclr_wr;
        logic mode_wr;
    } acc_stb_t;

    function automatic acc_stb_t decode_access(input logic wr, input logic rd,
                                               input reg_sel_e sel);
        acc_stb_t s;
        s.cause_rd = rd && (sel == SEL_CAUSE);
        s.cause_wr = wr && (sel == SEL_CAUSE);
        s.set_wr   = wr && (sel == SEL_SET);
        s.mset_wr  = wr && (sel == SEL_MSET);
        s.mclr_wr  = wr && (sel == SEL_MCLR);
        s.mode_wr  = wr && (sel == SEL_MODE);
        return s;
    endfunction

endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
    import irq_cause_pkg::*;
(
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [SEL_W-1:0] bus_addr,
    output reg_sel_e         sel,
    output acc_stb_t         stb
);
    always_comb begin
        sel = reg_sel_e'(bus_addr);
        stb = decode_access(bus_wr, bus_rd, sel);
    end
endmodule

// File: rtl/irq_cause_store.sv
module irq_cause_store
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_stb_t     stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_evt,
    input  logic [W-1:0] mode_q,
    output logic [W-1:0] cause_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic rd_clr;
        logic wr_clr;
        logic raise;

        always_comb begin
            rd_clr = stb.cause_rd && mode_q[i];
            wr_clr = stb.cause_wr && wdata[i] && !mode_q[i];
            raise  = hw_evt[i] || (stb.set_wr && wdata[i]);
        end

        always_ff @(posedge clk) begin
            if (rst)
                cause_q[i] <= 1'b0;
            else if (raise)
                cause_q[i] <= 1'b1;
            else if (rd_clr || wr_clr)
                cause_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctrl_store.sv
module irq_ctrl_store
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_stb_t     stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            mode_q <= '0;
        end else begin
            if (stb.mset_wr)
                mask_q <= mask_q | wdata;
            else if (stb.mclr_wr)
                mask_q <= mask_q & ~wdata;
            if (stb.mode_wr)
                mode_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  logic [W-1:0] cause_q,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] mode_q,
    output logic [W-1:0] rdata,
    output logic         irq
);
    logic [W-1:0] pending;
    logic [W-1:0] mux_val;

    always_comb begin
        pending = cause_q & ~mask_q;
        irq     = |pending;
        unique case (sel)
            SEL_CAUSE: mux_val = cause_q;
            SEL_MODE:  mux_val = mode_q;
            SEL_MVAL:  mux_val = mask_q;
            SEL_PEND:  mux_val = pending;
            default:   mux_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= mux_val;
        else
            rdata <= '0;
    end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     hw_evt,
    output logic             irq_out
);
    reg_sel_e     sel;
    acc_stb_t     stb;
    logic [W-1:0] cause_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] mode_q;

    irq_cause_decode u_decode (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .sel      (sel),
        .stb      (stb)
    );

    irq_ctrl_store #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata),
        .mask_q (mask_q),
        .mode_q (mode_q)
    );

    irq_cause_store #(.W(W)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .wdata   (bus_wdata),
        .hw_evt  (hw_evt),
        .mode_q  (mode_q),
        .cause_q (cause_q)
    );

    irq_read_port #(.W(W)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd      (bus_rd),
        .sel     (sel),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .mode_q  (mode_q),
        .rdata   (bus_rdata),
        .irq     (irq_out)
    );
endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk
    import irq_cause_pkg::*;
#(
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [SEL_W-1:0] bus_addr,
    input logic [W-1:0]     bus_wdata,
    input logic [W-1:0]     hw_evt,
    input logic [W-1:0]     cause_q,
    input logic [W-1:0]     mask_q,
    input logic [W-1:0]     mode_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && cause_q == '0 && mode_q == '0));

    // Covers R11 too: a pulse lands even when a clear hits the same bit.
    assert_event_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (hw_evt != '0) |=> ((cause_q & $past(hw_evt)) == $past(hw_evt)));

    assert_cor_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == SEL_CAUSE)
        |=> ((cause_q & $past(mode_q) & ~$past(hw_evt)) == '0));

    assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_MSET)
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_MCLR)
        |=> ((mask_q & $past(bus_wdata)) == '0));

    assert_pend_read_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == SEL_PEND && hw_evt == '0)
        |=> (cause_q == $past(cause_q)));
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hw_evt    (hw_evt),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .mode_q    (mode_q)
);

// File: tb/irq_cause_bank_bench.sv
module irq_cause_bank_bench;
    import irq_cause_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] hw_evt = '0;
    logic         irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_cause_bank #(.W(W)) u_irq_cause_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_evt    (hw_evt),
        .irq_out   (irq_out)
    );

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic        exp_irq;
    } row_t;

    localparam int NROWS = 24;
    localparam row_t ROWS [NROWS] = '{
        '{K_RD, 3'd5, 32'h0,        32'hFFFFFFFF, 1'b0}, // 0  R1 mask all set
        '{K_RD, 3'd0, 32'h0,        32'h00000000, 1'b0}, // 1  R1 cause clear
        '{K_EV, 3'd0, 32'h00000011, 32'h0,        1'b0}, // 2  R2 events, masked
        '{K_RD, 3'd0, 32'h0,        32'h00000011, 1'b0}, // 3  R5 mode 0 keeps
        '{K_WR, 3'd3, 32'h00000001, 32'h0,        1'b1}, // 4  R7 unmask bit0
        '{K_RD, 3'd5, 32'h0,        32'hFFFFFFFE, 1'b1}, // 5  R9 mask value
        '{K_RD, 3'd6, 32'h0,        32'h00000001, 1'b1}, // 6  R9 pending
        '{K_WR, 3'd0, 32'h00000001, 32'h0,        1'b0}, // 7  R4 w1c bit0
        '{K_RD, 3'd0, 32'h0,        32'h00000010, 1'b0}, // 8  R4 bit4 kept
        '{K_WR, 3'd1, 32'h80000000, 32'h0,        1'b0}, // 9  R3 sw set
        '{K_WR, 3'd3, 32'h80000000, 32'h0,        1'b1}, // 10 R10 unmask bit31
        '{K_WR, 3'd2, 32'h00000000, 32'h0,        1'b1}, // 11 R6 zero word
        '{K_RD, 3'd5, 32'h0,        32'h7FFFFFFE, 1'b1}, // 12 R6 unchanged
        '{K_WR, 3'd2, 32'h80000000, 32'h0,        1'b0}, // 13 R6 remask
        '{K_WR, 3'd4, 32'hF7FFFFFF, 32'h0,        1'b0}, // 14 R8 mode word
        '{K_RD, 3'd4, 32'h0,        32'hF7FFFFFF, 1'b0}, // 15 R8 readback
        '{K_WR, 3'd1, 32'h08000001, 32'h0,        1'b1}, // 16 R3 sw set
        '{K_WR, 3'd0, 32'h80000011, 32'h0,        1'b1}, // 17 R4 cor ignores write
        '{K_RD, 3'd0, 32'h0,        32'h88000011, 1'b0}, // 18 R5 cor read
        '{K_RD, 3'd0, 32'h0,        32'h08000000, 1'b0}, // 19 R5 bit27 stays
        '{K_WR, 3'd0, 32'h08000000, 32'h0,        1'b0}, // 20 R4 bit27 w1c
        '{K_RD, 3'd0, 32'h0,        32'h00000000, 1'b0}, // 21 R4 empty
        '{K_RD, 3'd7, 32'h0,        32'h00000000, 1'b0}, // 22 R12 unused sel
        '{K_RD, 3'd1, 32'h0,        32'h00000000, 1'b0}  // 23 R12 write-only
    };

    function automatic string row_req(input int i);
        case (i)
            0, 1:       return "R1";
            2:          return "R2";
            3, 18, 19:  return "R5";
            4:          return "R7";
            5, 6:       return "R9";
            7, 8, 17, 20, 21: return "R4";
            9, 16:      return "R3";
            10:         return "R10";
            11, 12, 13: return "R6";
            14, 15:     return "R8";
            default:    return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d, input logic [31:0] ev);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; hw_evt = ev;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; hw_evt = '0;
    endtask

    task automatic do_rd(input logic [2:0] a, input logic [31:0] ev, output logic [31:0] got);
        bus_rd = 1'b1; bus_addr = a; hw_evt = ev;
        @(negedge clk);
        bus_rd = 1'b0; hw_evt = '0;
        got = bus_rdata;
    endtask

    task automatic do_ev(input logic [31:0] ev);
        hw_evt = ev;
        @(negedge clk);
        hw_evt = '0;
    endtask

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);
        chk("R12 idle rdata", bus_rdata, 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            case (ROWS[i].kind)
                K_WR: do_wr(ROWS[i].addr, ROWS[i].data, 32'h0);
                K_EV: do_ev(ROWS[i].data);
                default: begin
                    do_rd(ROWS[i].addr, 32'h0, got);
                    chk(row_req(i), got, ROWS[i].expv);
                end
            endcase
            chk({row_req(i), " irq"}, {31'b0, irq_out}, {31'b0, ROWS[i].exp_irq});
        end

        // R11: event and clear-on-read on bit0 in the same cycle
        do_ev(32'h00000001);
        do_rd(3'd0, 32'h00000001, got);
        chk("R11 read value", got, 32'h00000001);
        chk("R11 irq kept", {31'b0, irq_out}, 32'h1);
        do_rd(3'd0, 32'h0, got);
        chk("R11 bit survived", got, 32'h00000001);
        chk("R10 irq drops", {31'b0, irq_out}, 32'h0);

        // R11: event and write-one-to-clear on bit27 in the same cycle
        do_wr(3'd1, 32'h08000000, 32'h0);
        do_wr(3'd0, 32'h08000000, 32'h08000000);
        do_rd(3'd0, 32'h0, got);
        chk("R11 w1c collision", got, 32'h08000000);

        // R1: reset mid-run restores defaults
        do_wr(3'd3, 32'hFFFFFFFF, 32'h0);
        chk("R10 irq on", {31'b0, irq_out}, 32'h1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        do_rd(3'd5, 32'h0, got);
        chk("R1 mask after reset", got, 32'hFFFFFFFF);
        do_rd(3'd4, 32'h0, got);
        chk("R1 mode after reset", got, 32'h0);
        do_rd(3'd0, 32'h0, got);
        chk("R1 cause after reset", got, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule